// File: doc/BRIEF.md
# Byte-Parallel Configuration Receiver with Serial Unpacking

This block sits on the target side of a byte-wide configuration link. A fast system clock oversamples the host's bit clock, the host's active-low configuration request and the eight data lines. After a power-on hold period, and whenever the host releases the request line, the receiver lets go of its open-drain status line and waits for data. It captures one byte on a rising edge of the bit clock. It then hands that byte out one bit at a time, least significant bit first, on the eight falling edges that follow. Each bit comes with a single-cycle strobe.

A counter holds the number of bits still expected. When that count runs out, a done flag is raised and held, and the receiver ignores further bit-clock activity. Pulling the request line low at any time discards all progress, so the next release starts a fresh transfer.

Top module: `cfg_byte_rx`

## Requirements
- R1: From reset until POR_CYCLES clocks after `rst_n` is released, `status_drive_low` is 1 whatever `ncfg_in` does. During that time `cfg_done` and `bit_valid` stay 0.
- R2: While the synchronized `ncfg_in` is 0, `status_drive_low` is 1, `cfg_done` is 0, and any partially received byte and the bit count are cleared.
- R3: Once the power-on period is over and `ncfg_in` has been 1 for at least three clocks, `status_drive_low` is 0.
- R4: The first rising edge of `dclk_in` after release captures `data_in`.
- R5: Each of the eight falling edges of `dclk_in` that follow a capture emits one bit of the captured byte, bit 0 first and bit 7 last. Each bit is marked by `bit_valid` high for exactly one clock.
- R6: The rising edges between those falling edges capture nothing, so a change on `data_in` at those edges does not alter the emitted bits.
- R7: The rising edge after the eighth falling edge captures the next byte. A falling edge with no captured bits pending emits nothing.
- R8: `cfg_done` rises exactly one clock after the `bit_valid` pulse of bit number TOTAL_BITS. It then stays 1 until `ncfg_in` goes low or reset.
- R9: While `cfg_done` is 1, `dclk_in` edges produce no `bit_valid` pulse.
- R10: After `ncfg_in` is pulled low in the middle of a transfer and released again, the full TOTAL_BITS must be received before `cfg_done` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| ncfg_in | input | 1 | Active-low configuration request from the host |
| dclk_in | input | 1 | Host bit clock, asynchronous to `clk` |
| data_in | input | DATA_W | Configuration byte from the host |
| status_drive_low | output | 1 | 1 = pull the open-drain status line low, 0 = release it |
| bit_out | output | 1 | Current serialized bit |
| bit_valid | output | 1 | Single-cycle strobe that marks `bit_out` |
| cfg_done | output | 1 | Configuration complete, released high |

## Verification
Several properties are checked on every cycle: a held receiver comes out with no strobe and no done flag, strobes are never back to back, the done flag rises only right after a strobe, it stays up until the next hold, no strobe appears while it is up, and the power-on period never restarts. Only the bench scenarios can show the rest. These are the bit order and byte contents, the immunity to data changes at the intermediate rising edges, the count restart after an abort, and the exact release timing of the status line.

// File: rtl/cfg_rx_pkg.sv
// Shared types for the configuration receiver.
// Assumes: all users compile this package first.
package cfg_rx_pkg;
    // One-cycle edge events derived from a synchronized input.
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;
endpackage

// File: rtl/cfg_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes: each bit is sampled independently; a multi-bit bus must be stable
// around the moment its qualifying strobe is sampled.
module cfg_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage_q [STAGES];

    // Every stage resets to zero and takes the value of the previous stage.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/cfg_edge.sv
// Rising and falling edge detector on an already synchronized signal.
// Assumes: the input is synchronous to clk, and the previous value resets to 0.
module cfg_edge
    import cfg_rx_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sig_s,
    output edge_ev_t ev
);
    logic prev_q;

    // Remember last cycle's level.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sig_s;
    end

    assign ev.rise = sig_s & ~prev_q;
    assign ev.fall = ~sig_s & prev_q;
endmodule

// File: rtl/cfg_por.sv
// Power-on hold timer: busy for POR_CYCLES clocks after reset is released.
// Assumes: POR_CYCLES >= 1; only rst_n restarts the period.
module cfg_por #(
    parameter int POR_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    output logic busy
);
    localparam int CNT_W = $clog2(POR_CYCLES + 1);

    logic [CNT_W-1:0] cnt_q;

    assign busy = (cnt_q != CNT_W'(POR_CYCLES));

    // Count up to the limit, then saturate.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (busy) cnt_q <= cnt_q + 1'b1;
    end

    // The period never restarts without reset.
    p_por_no_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !busy);
endmodule

// File: rtl/cfg_serializer.sv
// Byte capture and bit unpacking engine with the expected-bit countdown.
// A rising edge captures a byte only when no bits remain from the previous one.
// Each falling edge with bits pending emits the next bit, LSB first. Done
// rises one clock after the last counted bit and freezes the engine.
// Assumes: edge events come from synchronized signals aligned with data_s;
// hold clears everything synchronously.
module cfg_serializer
    import cfg_rx_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int TOTAL_BITS = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  edge_ev_t          dclk_ev,
    input  logic [DATA_W-1:0] data_s,
    output logic              ser_bit,
    output logic              ser_valid,
    output logic              done
);
    localparam int LEFT_W = $clog2(DATA_W + 1);
    localparam int REM_W  = $clog2(TOTAL_BITS + 1);

    logic [DATA_W-1:0] shreg_q;
    logic [LEFT_W-1:0] left_q;
    logic [REM_W-1:0]  remain_q;
    logic              bit_q;
    logic              valid_q;
    logic              done_q;
    logic              active;

    assign active = !done_q && (remain_q != '0);

    // Capture, shift, count down, and flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            shreg_q  <= '0;
            left_q   <= '0;
            remain_q <= REM_W'(TOTAL_BITS);
            bit_q    <= 1'b0;
            valid_q  <= 1'b0;
            done_q   <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            done_q  <= done_q | (remain_q == '0);
            if (active) begin
                if (dclk_ev.rise && left_q == '0) begin
                    shreg_q <= data_s;
                    left_q  <= LEFT_W'(DATA_W);
                end else if (dclk_ev.fall && left_q != '0) begin
                    bit_q    <= shreg_q[0];
                    valid_q  <= 1'b1;
                    shreg_q  <= shreg_q >> 1;
                    left_q   <= left_q - 1'b1;
                    remain_q <= remain_q - 1'b1;
                end
            end
        end
    end

    assign ser_bit   = bit_q;
    assign ser_valid = valid_q;
    assign done      = done_q;

    // A hold leaves no strobe and no done flag behind.
    p_hold_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> (!done && !ser_valid));
    // Strobes come from separate falling edges and never touch.
    p_single_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ser_valid |=> !ser_valid);
    // Done stays up until the next hold.
    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hold) |=> done);
    // No bit leaves after completion.
    p_quiet_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !ser_valid);
endmodule

// File: rtl/cfg_byte_rx.sv
// Target-side byte configuration receiver (top).
// It synchronizes the link pins, runs the power-on hold, drives the open-drain
// status request, and unpacks each received byte into a strobed bit stream.
// Assumes: dclk_in phases last at least SYNC_STAGES+1 clk cycles, and data_in
// is stable around each dclk_in rising edge.
module cfg_byte_rx #(
    parameter int DATA_W      = 8,
    parameter int TOTAL_BITS  = 64,
    parameter int POR_CYCLES  = 1000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ncfg_in,
    input  logic              dclk_in,
    input  logic [DATA_W-1:0] data_in,
    output logic              status_drive_low,
    output logic              bit_out,
    output logic              bit_valid,
    output logic              cfg_done
);
    import cfg_rx_pkg::*;

    localparam int PIN_W = DATA_W + 2;

    logic [PIN_W-1:0]  pins_s;
    logic              ncfg_s;
    logic              dclk_s;
    logic [DATA_W-1:0] data_s;
    logic              por_busy;
    logic              hold;
    edge_ev_t          dclk_ev;

    cfg_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ncfg_in, dclk_in, data_in}),
        .sync_out (pins_s)
    );

    assign ncfg_s = pins_s[PIN_W-1];
    assign dclk_s = pins_s[PIN_W-2];
    assign data_s = pins_s[DATA_W-1:0];

    cfg_por #(.POR_CYCLES(POR_CYCLES)) u_por (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (por_busy)
    );

    cfg_edge u_dclk_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_s (dclk_s),
        .ev    (dclk_ev)
    );

    // Receiver is held while the power-on timer runs or the request is low.
    assign hold             = por_busy | ~ncfg_s;
    assign status_drive_low = hold;

    cfg_serializer #(.DATA_W(DATA_W), .TOTAL_BITS(TOTAL_BITS)) u_ser (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold      (hold),
        .dclk_ev   (dclk_ev),
        .data_s    (data_s),
        .ser_bit   (bit_out),
        .ser_valid (bit_valid),
        .done      (cfg_done)
    );

    // Completion follows the final strobe by exactly one clock.
    p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(bit_valid));
endmodule

// File: tb/cfg_byte_rx_test.sv
`timescale 1ns/1ps
module cfg_byte_rx_test;
    localparam int POR   = 20;
    localparam int TOTAL = 64;
    localparam int HALF  = 4;

    // {stimulus byte, expected stream with the first emitted bit in bit 7}
    localparam logic [15:0] VEC [8] = '{
        16'h01_80, 16'hA5_A5, 16'h0F_F0, 16'h12_48,
        16'hFF_FF, 16'h00_00, 16'h80_01, 16'h6B_D6
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ncfg_in = 1'b0;
    logic       dclk_in = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       status_drive_low, bit_out, bit_valid, cfg_done;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int nbits = 0;
    int last_valid_cyc = 0;
    int done_cyc = -1;
    logic [7:0] cap = 8'h00;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cfg_byte_rx #(.DATA_W(8), .TOTAL_BITS(TOTAL), .POR_CYCLES(POR)) uut (
        .clk(clk), .rst_n(rst_n), .ncfg_in(ncfg_in), .dclk_in(dclk_in),
        .data_in(data_in), .status_drive_low(status_drive_low),
        .bit_out(bit_out), .bit_valid(bit_valid), .cfg_done(cfg_done)
    );

    // Output monitor, sampled away from the active edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (bit_valid) begin
            cap <= {cap[6:0], bit_out};
            nbits <= nbits + 1;
            last_valid_cyc <= cyc;
        end
        if (cfg_done && done_cyc < 0) done_cyc <= cyc;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic [7:0] noise);
        data_in = b;
        dclk_in = 1'b1; tick(HALF);
        dclk_in = 1'b0; tick(HALF);
        for (int k = 1; k < 8; k++) begin
            data_in = noise;
            dclk_in = 1'b1; tick(HALF);
            dclk_in = 1'b0; tick(HALF);
        end
    endtask

    initial begin
        int base;
        tick(5);
        check(status_drive_low == 1'b1, "R1 status low in reset", status_drive_low, 1);
        check(cfg_done == 1'b0, "R1 done clear in reset", cfg_done, 0);
        rst_n = 1'b1;
        ncfg_in = 1'b1;
        tick(8);
        check(status_drive_low == 1'b1, "R1 status low during power-on", status_drive_low, 1);
        check(nbits == 0, "R1 no strobe during power-on", nbits, 0);
        tick(POR);
        check(status_drive_low == 1'b0, "R3 status released", status_drive_low, 0);

        // Partial transfer, then abort.
        send_byte(8'h55, 8'h00);
        send_byte(8'hAA, 8'hFF);
        tick(2);
        check(nbits == 16, "R5 two bytes give sixteen strobes", nbits, 16);
        check(cap == 8'h55, "R5 second byte LSB first", cap, 8'h55);
        ncfg_in = 1'b0;
        tick(4);
        check(status_drive_low == 1'b1, "R2 status low on request", status_drive_low, 1);
        dclk_in = 1'b1;
        tick(4);
        ncfg_in = 1'b1;
        tick(6);
        check(status_drive_low == 1'b0, "R3 status released again", status_drive_low, 0);
        base = nbits;
        dclk_in = 1'b0;
        tick(8);
        check(nbits == base, "R7 fall with nothing pending", nbits, base);

        // Table walk: full transfer after the restart.
        for (int i = 0; i < 8; i++) begin
            send_byte(VEC[i][15:8], ~VEC[i][15:8]);
            tick(2);
            check(cap == VEC[i][7:0], "R4/R6/R7 byte stream", cap, VEC[i][7:0]);
            if (i == 5)
                check(cfg_done == 1'b0, "R10 count restarted", cfg_done, 0);
        end
        check(nbits - base == TOTAL, "R5 strobe count", nbits - base, TOTAL);
        check(cfg_done == 1'b1, "R8 done after last bit", cfg_done, 1);
        check(done_cyc - last_valid_cyc == 1, "R8 done timing", done_cyc - last_valid_cyc, 1);

        base = nbits;
        send_byte(8'hFF, 8'h00);
        check(nbits == base, "R9 edges ignored after done", nbits, base);
        check(cfg_done == 1'b1, "R8 done held", cfg_done, 1);

        ncfg_in = 1'b0;
        tick(4);
        check(cfg_done == 1'b0, "R2 done cleared by request", cfg_done, 0);
        check(status_drive_low == 1'b1, "R2 status low after done", status_drive_low, 1);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule